// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block moves outgoing frames from system memory to a byte-stream transmitter. Software places a ring of 8-byte descriptors in memory. Each descriptor names a buffer and its length, and carries flags for ownership, ring wrap and end of frame. Software then pulses a transmit-demand strobe. The engine reads descriptors from its current position through a simple request/acknowledge memory master port. It gathers the bytes of one or more buffers into an internal frame store. It starts streaming the frame out over a valid/ready byte interface only once it has consumed the descriptor marked as the last of the frame.

After each buffer has been gathered, the engine writes the descriptor back with its ownership bit cleared and pulses a per-buffer event. A per-frame event follows the final byte handshake. The frame is capped at a fixed maximum size. A buffer that would overrun the cap is cut short, and a babbling-transmit event is raised for it. The walk stops at the first descriptor that software has not handed over. A demand that arrives during a walk is remembered and triggers a fresh look at the current descriptor. The engine adds no frame check sequence and does not handle collisions.

Top module: `tx_ring_engine`

## Requirements
- R1: After reset, mem_req, tx_valid and all three event outputs are low.
- R2: A tx_demand pulse while ctrl_en is low has no effect: no memory request is issued.
- R3: Descriptor word 0 at the current address holds flags in bits 31:16 and length in bits 15:0. Word 1, at address +4, holds the buffer pointer. Flag bit 15 = ready, bit 13 = wrap, bit 11 = last. A walk ends at the first descriptor whose ready bit is 0, and that descriptor is left untouched.
- R4: Buffer bytes are gathered in address order from any byte alignment. Within a memory word, the byte at the lowest address is bits 31:24. The frame is streamed only after the last-flagged descriptor is consumed, and tx_last marks its final byte.
- R5: Each consumed descriptor is written back to word 0 with flag bit 15 cleared, the other flags kept and the length unchanged. ev_buf_done pulses once per consumed descriptor.
- R6: ev_frame_done pulses in the cycle after the handshake of the byte carrying tx_last.
- R7: When the gathered total plus the buffer length exceeds MAX_FRAME (2032), only the bytes that fit are taken and ev_babble pulses once for that descriptor. Later buffers of the same frame contribute no bytes and each raises ev_babble again.
- R8: The next descriptor is 8 bytes further on, or at the ring base when the consumed descriptor has its wrap flag set.
- R9: A ring-base write clears the low 2 bits of the value and moves the current descriptor pointer to that base.
- R10: A demand accepted while a walk is in progress makes the engine re-read the current descriptor after the walk ends.
- R11: mem_req, mem_addr and mem_we stay stable until mem_ack, and every address is word aligned. tx_valid, tx_data and tx_last stay stable while tx_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_en | input | 1 | Controller enable; demands are accepted only while high |
| tx_demand | input | 1 | Single-cycle transmit-demand strobe |
| ring_base_we | input | 1 | Write strobe for the ring base |
| ring_base_wdata | input | 32 | New ring base address |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data (descriptor word 0) |
| mem_ack | input | 1 | One-cycle acknowledge; read data valid with it |
| mem_rdata | input | 32 | Read data |
| tx_data | output | 8 | Outgoing frame byte |
| tx_valid | output | 1 | tx_data holds a frame byte |
| tx_last | output | 1 | Byte is the final byte of the frame |
| tx_ready | input | 1 | Sink accepts the byte |
| ev_buf_done | output | 1 | Pulse per consumed descriptor |
| ev_frame_done | output | 1 | Pulse per streamed frame |
| ev_babble | output | 1 | Pulse per clamped buffer |

## Verification
The gather path is tried with four descriptor patterns:
- A single word-aligned buffer.
- A three-buffer frame whose pointers sit at offsets 1, 3 and 2 inside their words. This separates correct big-endian byte selection and word refetch from an implementation that assumes aligned buffers.
- A three-descriptor ring ending in a wrap flag, followed by a reload of the first slot. This shows that the pointer returns to the base rather than running on.
- A 2000 + 100 + 10 byte frame sent under a stuttering tx_ready. This exercises the clamp to 2032 bytes, the repeated babble event and output holding together.

A descriptor with ready clear is placed behind each walk to confirm the stop condition. A demand issued while the engine is disabled, and a second demand during a walk, show the gating and the remembered demand, observed through header re-reads on the memory port.

// File: rtl/tx_ring_engine.sv
module tx_ring_engine #(
  parameter int MAX_FRAME = 2032
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctrl_en,
  input  logic        tx_demand,
  input  logic        ring_base_we,
  input  logic [31:0] ring_base_wdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic [7:0]  tx_data,
  output logic        tx_valid,
  output logic        tx_last,
  input  logic        tx_ready,
  output logic        ev_buf_done,
  output logic        ev_frame_done,
  output logic        ev_babble
);
  localparam int CW = $clog2(MAX_FRAME + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_HDR, S_PTR, S_DATA, S_COPY, S_WB, S_SEND, S_NEXT
  } state_t;

  state_t        state;
  logic [31:0]   base, cur, dptr, word;
  logic [15:0]   flags, blen;
  logic [CW-1:0] acc, take, sidx;
  logic          pend;
  logic [7:0]    fbuf [MAX_FRAME];

  logic [CW-1:0] room, take_n;
  logic          clamp;
  logic [31:0]   shifted;

  assign room    = CW'(MAX_FRAME) - acc;
  assign clamp   = 32'(blen) > 32'(room);
  assign take_n  = clamp ? room : blen[CW-1:0];
  assign shifted = word << {dptr[1:0], 3'b000};

  assign mem_req   = (state == S_HDR) || (state == S_PTR) ||
                     (state == S_DATA) || (state == S_WB);
  assign mem_we    = (state == S_WB);
  assign mem_wdata = {flags & 16'h7fff, blen};

  always_comb begin
    case (state)
      S_PTR:   mem_addr = cur + 32'd4;
      S_DATA:  mem_addr = dptr & ~32'd3;
      default: mem_addr = cur;
    endcase
  end

  assign tx_valid = (state == S_SEND) && (acc != '0);
  assign tx_data  = fbuf[sidx];
  assign tx_last  = (sidx == acc - 1'b1);

  always_ff @(posedge clk) begin
    if (state == S_COPY) fbuf[acc] <= shifted[31:24];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= S_IDLE;
      base          <= '0;
      cur           <= '0;
      dptr          <= '0;
      word          <= '0;
      flags         <= '0;
      blen          <= '0;
      acc           <= '0;
      take          <= '0;
      sidx          <= '0;
      pend          <= 1'b0;
      ev_buf_done   <= 1'b0;
      ev_frame_done <= 1'b0;
      ev_babble     <= 1'b0;
    end else begin
      ev_buf_done   <= 1'b0;
      ev_frame_done <= 1'b0;
      ev_babble     <= 1'b0;

      if (tx_demand && ctrl_en) pend <= 1'b1;
      else if (state == S_IDLE) pend <= 1'b0;

      case (state)
        S_IDLE: if (pend) state <= S_HDR;
        S_HDR: if (mem_ack) begin
          if (mem_rdata[31]) begin
            flags <= mem_rdata[31:16];
            blen  <= mem_rdata[15:0];
            state <= S_PTR;
          end else begin
            state <= S_IDLE;
          end
        end
        S_PTR: if (mem_ack) begin
          dptr      <= mem_rdata;
          take      <= take_n;
          ev_babble <= clamp;
          state     <= (take_n == '0) ? S_WB : S_DATA;
        end
        S_DATA: if (mem_ack) begin
          word  <= mem_rdata;
          state <= S_COPY;
        end
        S_COPY: begin
          acc  <= acc + 1'b1;
          dptr <= dptr + 32'd1;
          take <= take - 1'b1;
          if (take == CW'(1))          state <= S_WB;
          else if (dptr[1:0] == 2'b11) state <= S_DATA;
        end
        S_WB: if (mem_ack) begin
          ev_buf_done <= 1'b1;
          sidx        <= '0;
          state       <= flags[11] ? S_SEND : S_NEXT;
        end
        S_SEND: begin
          if (acc == '0) begin
            ev_frame_done <= 1'b1;
            state         <= S_NEXT;
          end else if (tx_ready) begin
            if (tx_last) begin
              ev_frame_done <= 1'b1;
              acc           <= '0;
              state         <= S_NEXT;
            end else begin
              sidx <= sidx + 1'b1;
            end
          end
        end
        S_NEXT: state <= S_HDR;
        default: state <= S_IDLE;
      endcase

      if (ring_base_we) begin
        base <= ring_base_wdata & ~32'd3;
        cur  <= ring_base_wdata & ~32'd3;
      end else if (state == S_NEXT) begin
        cur <= flags[13] ? base : cur + 32'd8;
      end
    end
  end
endmodule

// File: rtl/tx_ring_engine_chk.sv
module tx_ring_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        mem_ack,
  input logic [7:0]  tx_data,
  input logic        tx_valid,
  input logic        tx_last,
  input logic        tx_ready,
  input logic        ev_frame_done
);
  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  p_aligned_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00);

  p_wb_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> !mem_wdata[31]);

  p_out_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

  p_frame_evt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready && tx_last |=> ev_frame_done);
endmodule

bind tx_ring_engine tx_ring_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
  .tx_data(tx_data), .tx_valid(tx_valid), .tx_last(tx_last),
  .tx_ready(tx_ready), .ev_frame_done(ev_frame_done)
);

// File: tb/tb_tx_ring_engine.sv
module tb_tx_ring_engine;
  localparam int MAXF = 2032;
  localparam int MASK = 8191;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctrl_en = 1'b0, tx_demand = 1'b0, ring_base_we = 1'b0;
  logic [31:0] ring_base_wdata = '0;
  logic mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [7:0] tx_data;
  logic tx_valid, tx_last, tx_ready;
  logic ev_buf_done, ev_frame_done, ev_babble;

  always #5 clk = ~clk;

  tx_ring_engine dut (.*);

  logic [7:0] m [0:MASK];
  int checks = 0, fails = 0, cyc = 0;
  int n_buf = 0, n_frame = 0, n_bab = 0;
  int exp_buf = 0, exp_frame = 0, exp_bab = 0;
  int req_cycles = 0, watch_reads = 0;
  logic [31:0] watch_addr = 32'hffff_fff0, first_addr = '0;
  bit cap_first = 0, bp = 0, done = 0;
  logic [7:0] exp_q[$];
  bit exp_last_q[$];
  logic [31:0] wb_addr_q[$];
  logic [15:0] wb_flags_q[$], wb_len_q[$];
  logic [31:0] mbase = '0, mcur = '0;
  int macc = 0;
  logic [7:0] fq[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] rd16(input logic [31:0] a);
    return {m[a & MASK], m[(a + 1) & MASK]};
  endfunction
  function automatic logic [31:0] rd32(input logic [31:0] a);
    return {rd16(a), rd16(a + 2)};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) mem_ack <= 1'b0;
    else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && !mem_ack) begin
        mem_rdata <= rd32(mem_addr & ~32'd3);
        if (mem_we) for (int i = 0; i < 4; i++)
          m[(mem_addr + i) & MASK] <= mem_wdata[31 - 8*i -: 8];
        if (!mem_we && mem_addr == watch_addr) watch_reads++;
        if (cap_first) begin first_addr <= mem_addr; cap_first <= 0; end
      end
    end
  end

  always @(negedge clk) begin
    cyc++;
    tx_ready = bp ? (cyc % 3 != 1) : 1'b1;
    if (rst_n) begin
      if (mem_req) req_cycles++;
      n_buf   += int'(ev_buf_done);
      n_frame += int'(ev_frame_done);
      n_bab   += int'(ev_babble);
      if (tx_valid && tx_ready) begin
        if (exp_q.size() == 0) chk(0, "R4", "unexpected byte", tx_data, 0);
        else begin
          chk(tx_data == exp_q[0], "R4", "byte", tx_data, exp_q[0]);
          chk(tx_last == exp_last_q[0], "R4", "last flag", tx_last, exp_last_q[0]);
          void'(exp_q.pop_front());
          void'(exp_last_q.pop_front());
        end
      end
    end
    if (cyc > 150000 && !done) begin
      done = 1;
      chk(0, "WDOG", "watchdog expired", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic put_desc(input logic [31:0] a, input logic [15:0] fl,
                          input logic [15:0] ln, input logic [31:0] p);
    logic [63:0] v;
    v = {fl, ln, p};
    for (int i = 0; i < 8; i++) m[(a + i) & MASK] = v[63 - 8*i -: 8];
  endtask

  task automatic fill(input logic [31:0] p, input int n, input int seed);
    for (int i = 0; i < n; i++) m[(p + i) & MASK] = 8'((seed + i * 7) & 8'hff);
  endtask

  task automatic set_base(input logic [31:0] v);
    @(negedge clk); ring_base_we = 1; ring_base_wdata = v;
    @(negedge clk); ring_base_we = 0;
    mbase = v & ~32'd3; mcur = mbase;
  endtask

  task automatic kick();
    @(negedge clk); tx_demand = 1;
    @(negedge clk); tx_demand = 0;
  endtask

  task automatic model_walk();
    bit gone[int];
    logic [15:0] fl, ln;
    logic [31:0] pt;
    int room, take;
    for (int g = 0; g < 64; g++) begin
      fl = rd16(mcur);
      if (!fl[15] || gone.exists(int'(mcur))) break;
      gone[int'(mcur)] = 1;
      ln = rd16(mcur + 2); pt = rd32(mcur + 4);
      room = MAXF - macc;
      take = (int'(ln) > room) ? room : int'(ln);
      if (int'(ln) > room) exp_bab++;
      for (int i = 0; i < take; i++) fq.push_back(m[(pt + i) & MASK]);
      macc += take;
      exp_buf++;
      wb_addr_q.push_back(mcur); wb_flags_q.push_back(fl & 16'h7fff); wb_len_q.push_back(ln);
      if (fl[11]) begin
        for (int i = 0; i < fq.size(); i++) begin
          exp_q.push_back(fq[i]); exp_last_q.push_back(i == fq.size() - 1);
        end
        exp_frame++; fq.delete(); macc = 0;
      end
      mcur = fl[13] ? mbase : mcur + 32'd8;
    end
  endtask

  task automatic wait_idle();
    int quiet;
    quiet = 0;
    for (int i = 0; i < 8000 && quiet < 12; i++) begin
      @(negedge clk);
      quiet = (!mem_req && !tx_valid) ? quiet + 1 : 0;
    end
  endtask

  task automatic check_all(input string tag);
    chk(exp_q.size() == 0, "R4", {tag, " bytes left unsent"}, exp_q.size(), 0);
    while (wb_addr_q.size() > 0) begin
      chk(rd16(wb_addr_q[0]) == wb_flags_q[0], "R5", {tag, " written-back flags"},
          rd16(wb_addr_q[0]), wb_flags_q[0]);
      chk(rd16(wb_addr_q[0] + 2) == wb_len_q[0], "R5", {tag, " written-back length"},
          rd16(wb_addr_q[0] + 2), wb_len_q[0]);
      void'(wb_addr_q.pop_front()); void'(wb_flags_q.pop_front()); void'(wb_len_q.pop_front());
    end
    chk(n_buf == exp_buf, "R5", {tag, " buffer events"}, n_buf, exp_buf);
    chk(n_frame == exp_frame, "R6", {tag, " frame events"}, n_frame, exp_frame);
    chk(n_bab == exp_bab, "R7", {tag, " babble events"}, n_bab, exp_bab);
  endtask

  initial begin
    for (int i = 0; i <= MASK; i++) m[i] = 8'h00;
    repeat (4) @(negedge clk);
    chk(!mem_req && !tx_valid, "R1", "req/valid in reset", {mem_req, tx_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    chk({mem_req, tx_valid, ev_buf_done, ev_frame_done, ev_babble} == 0, "R1",
        "outputs after reset", {mem_req, tx_valid, ev_buf_done, ev_frame_done, ev_babble}, 0);

    // R2: demand while disabled
    set_base(32'h100);
    put_desc(32'h100, 16'h8800, 16'd5, 32'h1000); fill(32'h1000, 5, 3);
    req_cycles = 0;
    kick(); repeat (30) @(negedge clk);
    chk(req_cycles == 0, "R2", "memory requests while disabled", req_cycles, 0);

    // R3/R4: single aligned buffer, walk stops at empty slot
    ctrl_en = 1; watch_addr = 32'h108; watch_reads = 0;
    model_walk(); kick(); wait_idle();
    check_all("single");
    chk(watch_reads == 1, "R3", "stop slot header reads", watch_reads, 1);
    chk(rd16(32'h108) == 16'h0000, "R3", "stop slot untouched", rd16(32'h108), 0);

    // R4: multi-buffer frame at odd alignments
    put_desc(32'h108, 16'h8000, 16'd3, 32'h1101); fill(32'h1101, 3, 40);
    put_desc(32'h110, 16'h8000, 16'd1, 32'h1123); fill(32'h1123, 1, 90);
    put_desc(32'h118, 16'h8800, 16'd6, 32'h1142); fill(32'h1142, 6, 17);
    model_walk(); kick(); wait_idle();
    check_all("gather");

    // R8: wrap back to ring base
    set_base(32'h200);
    put_desc(32'h200, 16'h8800, 16'd4, 32'h1200); fill(32'h1200, 4, 5);
    put_desc(32'h208, 16'h8000, 16'd2, 32'h1210); fill(32'h1210, 2, 60);
    put_desc(32'h210, 16'hA800, 16'd3, 32'h1221); fill(32'h1221, 3, 77);
    model_walk(); kick(); wait_idle();
    check_all("ring");
    put_desc(32'h200, 16'h8800, 16'd7, 32'h1230); fill(32'h1230, 7, 200);
    cap_first = 1;
    model_walk(); kick(); wait_idle();
    chk(first_addr == 32'h200, "R8", "first fetch after wrap", first_addr, 32'h200);
    check_all("wrap");

    // R7 + R11: overlong frame under backpressure
    set_base(32'h400); bp = 1;
    put_desc(32'h400, 16'h8000, 16'd2000, 32'h1000); fill(32'h1000, 2000, 11);
    put_desc(32'h408, 16'h8000, 16'd100, 32'h1800); fill(32'h1800, 100, 33);
    put_desc(32'h410, 16'h8800, 16'd10, 32'h1900); fill(32'h1900, 10, 55);
    model_walk(); kick(); wait_idle();
    check_all("babble");
    bp = 0;

    // R9 + R10: base low bits dropped; demand during walk
    set_base(32'h303);
    put_desc(32'h300, 16'h8800, 16'd4, 32'h1300); fill(32'h1300, 4, 99);
    watch_addr = 32'h308; watch_reads = 0; cap_first = 1;
    model_walk(); kick(); repeat (2) @(negedge clk); kick(); wait_idle();
    chk(first_addr == 32'h300, "R9", "fetch address after base write", first_addr, 32'h300);
    chk(watch_reads == 2, "R10", "re-check of current slot", watch_reads, 2);
    check_all("pending");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule